// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block is a free-running cycle counter, 64 bits wide by default, that software reads over a 32-bit register bus. The bus carries the count as two separate words. A read of the low word followed by a read of the high word can return a torn value. This happens if the high half moved between the two accesses, or if the reading thread was interrupted in between.

The block does not rely on software locking. A small tracker watches the order of the reads and compares the high half seen at the low read with the high half returned later. It also records any interrupt-taken strobe that arrives inside that window. Software reads the low word, then the high word, then the control word, and repeats the sequence until the status bit says the pair was consistent. The control word also holds the counter enable.

Register map (word addresses, parameters): control 0x103, low word 0x104, high word 0x105. Reads return data on `rdata_o` one clock after the request, and `rdata_o` holds its value between reads. The split point between the low and high words is a parameter (`LO_W`, default 32).

Top module: `split_read_counter`

## Requirements
- R1: After reset the count, the enable, the tracking state and `rdata_o` are all 0, so a control read returns 0.
- R2: A write to control loads the enable from data bit 0 and ignores all other data bits. A control read returns the enable in bit 0, the status in bit 31, and 0 in bits 30 to 1.
- R3: While enabled, the count rises by exactly one each clock and wraps at full width. While disabled it holds. Reads never change it.
- R4: A read returns its data one clock after the request: the low `LO_W` bits of the count for the low word, the remaining upper bits for the high word, and 0 for an unmapped address. Without a read, `rdata_o` holds.
- R5: A low-word read clears the status bit and opens a new tracking window.
- R6: The status bit reads 1 after a low read is followed by a high read when the high half is unchanged and no interrupt arrived. Control reads in between do not close the window.
- R7: The status bit reads 0 if the high half of the count differs at the high read from its value at the low read.
- R8: The status bit reads 0 if the interrupt strobe is high in any cycle after the low read, up to and including the high-read cycle. A strobe in the low-read cycle itself does not count.
- R9: A high read with no open window (no low read since the last high read) sets the status bit to 0.
- R10: Writes to the low word, the high word or unmapped addresses have no effect on the count or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| irq_taken_i | input | 1 | Strobe: an interrupt or exception was taken this cycle |
| rdata_o | output | DATA_W | Read data, valid one cycle after a read request |

## Verification
A wrong snapshot or a missed interrupt in the tracker has no visible effect until software reads the control word. At that point bit 31 disagrees with the bench's own model of the window. So each window is closed with a control read in the very next cycle, which exposes a bad status within two clocks of the high read. A counter fault shows up on the next low or high read as a word that differs from the cycle count the bench keeps. The bench shrinks the count to 20 bits with an 8-bit low word, so the high half rolls over every 256 cycles. This puts windows that straddle a carry in reach of both directed and random stimulus.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  typedef struct packed {
    logic rd_any;
    logic rd_ctrl;
    logic rd_lo;
    logic rd_hi;
    logic wr_ctrl;
  } bus_dec_t;
endpackage

// File: rtl/srtc_decode.sv
module srtc_decode
  import srtc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CTRL_ADDR = 'h103,
  parameter int LO_ADDR   = 'h104,
  parameter int HI_ADDR   = 'h105
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_dec_t          dec_o
);
  logic rd, wr;
  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  always_comb begin
    dec_o         = '0;
    dec_o.rd_any  = rd;
    dec_o.rd_ctrl = rd && (addr_i == ADDR_W'(CTRL_ADDR));
    dec_o.rd_lo   = rd && (addr_i == ADDR_W'(LO_ADDR));
    dec_o.rd_hi   = rd && (addr_i == ADDR_W'(HI_ADDR));
    dec_o.wr_ctrl = wr && (addr_i == ADDR_W'(CTRL_ADDR));
  end
endmodule

// File: rtl/srtc_counter.sv
module srtc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             en_val_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_en_i) en_q <= en_val_i;
      // increment uses the enable in force before this edge
      if (en_q) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/srtc_tracker.sv
module srtc_tracker #(
  parameter int HI_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_lo_i,
  input  logic            rd_hi_i,
  input  logic            irq_i,
  input  logic [HI_W-1:0] hi_now_i,
  output logic            valid_o
);
  logic            armed_q, taint_q, valid_q;
  logic [HI_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      taint_q <= 1'b0;
      valid_q <= 1'b0;
      snap_q  <= '0;
    end else if (rd_lo_i) begin
      armed_q <= 1'b1;
      taint_q <= 1'b0;
      valid_q <= 1'b0;
      snap_q  <= hi_now_i;
    end else if (rd_hi_i) begin
      valid_q <= armed_q && !taint_q && !irq_i && (hi_now_i == snap_q);
      armed_q <= 1'b0;
      taint_q <= 1'b0;
    end else if (armed_q && irq_i) begin
      taint_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/split_read_counter.sv
module split_read_counter
  import srtc_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int LO_W      = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CTRL_ADDR = 'h103,
  parameter int LO_ADDR   = 'h104,
  parameter int HI_ADDR   = 'h105
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_taken_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = CNT_W - LO_W;

  bus_dec_t          dec;
  logic              en;
  logic [CNT_W-1:0]  cnt;
  logic              valid;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  srtc_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_decode (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .dec_o (dec)
  );

  srtc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (dec.wr_ctrl),
    .en_val_i(wdata_i[0]),
    .en_o    (en),
    .cnt_o   (cnt)
  );

  srtc_tracker #(.HI_W(HI_W)) u_tracker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_lo_i (dec.rd_lo),
    .rd_hi_i (dec.rd_hi),
    .irq_i   (irq_taken_i),
    .hi_now_i(cnt[CNT_W-1:LO_W]),
    .valid_o (valid)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.rd_ctrl) begin
      rd_mux[DATA_W-1] = valid;
      rd_mux[0]        = en;
    end else if (dec.rd_lo) begin
      rd_mux[LO_W-1:0] = cnt[LO_W-1:0];
    end else if (dec.rd_hi) begin
      rd_mux[HI_W-1:0] = cnt[CNT_W-1:LO_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (dec.rd_any) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/srtc_chk.sv
module srtc_chk #(
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int LO_ADDR = 'h104,
  parameter int HI_ADDR = 'h105,
  parameter int CTRL_ADDR = 'h103
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_taken_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              en_q,
  input logic              valid_q
);
  logic rd;
  assign rd = req_i && !we_i;

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(cnt_q));

  // R5
  lo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(LO_ADDR)) |=> !valid_q);

  // R8
  irq_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(HI_ADDR) && irq_taken_i) |=> !valid_q);

  // R2
  ctrl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(CTRL_ADDR)) |=>
      (rdata_o[DATA_W-2:1] == '0) && (rdata_o[0] == $past(en_q)));

  // R4
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind split_read_counter srtc_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .irq_taken_i(irq_taken_i),
  .rdata_o    (rdata_o),
  .cnt_q      (cnt),
  .en_q       (en),
  .valid_q    (valid)
);

// File: tb/split_read_counter_test.sv
module split_read_counter_test;
  localparam int CNT_W = 20;
  localparam int LO_W  = 8;
  localparam int HI_W  = CNT_W - LO_W;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LO   = 12'h104;
  localparam logic [11:0] A_HI   = 12'h105;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, irq = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_run = 0, n_fail = 0;

  // reference state
  logic [CNT_W-1:0] cnt_m;
  logic             en_m, armed_m, taint_m, valid_m;
  logic [HI_W-1:0]  snap_m;
  logic [31:0]      last_m;

  always #10 clk = ~clk;

  split_read_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .irq_taken_i(irq), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] d = '0;
    if (a == A_CTRL) begin d[31] = valid_m; d[0] = en_m; end
    else if (a == A_LO) d[LO_W-1:0] = cnt_m[LO_W-1:0];
    else if (a == A_HI) d[HI_W-1:0] = cnt_m[CNT_W-1:LO_W];
    return d;
  endfunction

  task automatic model_clear();
    cnt_m = '0; en_m = 0; armed_m = 0; taint_m = 0; valid_m = 0; snap_m = '0; last_m = '0;
  endtask

  // one bus cycle, called at a negedge
  task automatic cyc(input logic rq, input logic w, input logic [11:0] a,
                     input logic [31:0] wd, input logic ir, input string tag);
    logic rd = rq && !w;
    logic [HI_W-1:0] hi = cnt_m[CNT_W-1:LO_W];
    req = rq; we = w; addr = a; wdata = wd; irq = ir;
    if (rd) last_m = exp_read(a);
    if (rd && a == A_LO) begin
      armed_m = 1; taint_m = 0; valid_m = 0; snap_m = hi;
    end else if (rd && a == A_HI) begin
      valid_m = armed_m && !taint_m && !ir && (hi == snap_m);
      armed_m = 0; taint_m = 0;
    end else if (armed_m && ir) taint_m = 1;
    if (en_m) cnt_m = cnt_m + 1'b1;
    if (rq && w && a == A_CTRL) en_m = wd[0];
    @(negedge clk);
    req = 0; we = 0; irq = 0;
    check(rd ? tag : "R4 hold", rdata, last_m);
  endtask

  task automatic rd_(input logic [11:0] a, input string tag);
    cyc(1, 0, a, '0, 0, tag);
  endtask

  task automatic idle(input logic ir);
    cyc(0, 0, '0, '0, ir, "R4 hold");
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd2024);
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_(A_CTRL, "R1 ctrl");
    rd_(A_LO, "R3 disabled"); rd_(A_LO, "R3 disabled");
    rd_(A_HI, "R1 hi");
    cyc(1, 1, A_CTRL, 32'h0000_0001, 0, "R2");
    rd_(A_CTRL, "R2 enable readback");
    repeat (5) idle(0);
    rd_(A_LO, "R3 count"); rd_(A_LO, "R3 count");
    // consistent pair
    while (cnt_m[LO_W-1:0] > 8'hF0) idle(0);
    rd_(A_LO, "R6 lo"); rd_(A_HI, "R6 hi"); rd_(A_CTRL, "R6 valid");
    rd_(A_LO, "R5 lo"); rd_(A_CTRL, "R5 cleared");
    rd_(A_HI, "R6 hi"); rd_(A_CTRL, "R6 interleaved ctrl");
    // interrupt inside window
    while (cnt_m[LO_W-1:0] > 8'hF0) idle(0);
    rd_(A_LO, "R8 lo"); idle(1); rd_(A_HI, "R8 hi"); rd_(A_CTRL, "R8 irq in window");
    rd_(A_LO, "R8 lo"); cyc(1, 0, A_HI, '0, 1, "R8 hi"); rd_(A_CTRL, "R8 irq at hi");
    cyc(1, 0, A_LO, '0, 1, "R8 lo"); rd_(A_HI, "R8 hi"); rd_(A_CTRL, "R8 irq at lo ignored");
    // carry into the high half inside the window
    while (cnt_m[LO_W-1:0] != 8'hFD) idle(0);
    rd_(A_LO, "R7 lo"); idle(0); idle(0); idle(0);
    rd_(A_HI, "R7 hi"); rd_(A_CTRL, "R7 high changed");
    // high read with no open window
    while (cnt_m[LO_W-1:0] > 8'hF0) idle(0);
    rd_(A_LO, "R9 lo"); rd_(A_HI, "R9 hi"); rd_(A_HI, "R9 hi again");
    rd_(A_CTRL, "R9 no window");
    // ignored writes and unmapped
    cyc(1, 1, A_LO, 32'hDEAD_BEEF, 0, "R10");
    cyc(1, 1, A_HI, 32'hFFFF_FFFF, 0, "R10");
    cyc(1, 1, 12'h200, 32'h0, 0, "R10");
    rd_(A_LO, "R10 lo"); rd_(A_HI, "R10 hi"); rd_(A_CTRL, "R10 ctrl");
    rd_(12'h100, "R4 unmapped");
    // disable via bit 0 only
    cyc(1, 1, A_CTRL, 32'hFFFF_FFFE, 0, "R2");
    rd_(A_CTRL, "R2 disable");
    repeat (3) idle(0);
    rd_(A_LO, "R3 held"); rd_(A_HI, "R3 held");
    cyc(1, 1, A_CTRL, 32'h1, 0, "R2");
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      int unsigned r = $urandom % 100;
      logic ir = ($urandom % 10) == 0;
      if (r < 25)      cyc(1, 0, A_LO, '0, ir, "R5 rand lo");
      else if (r < 50) cyc(1, 0, A_HI, '0, ir, "R4 rand hi");
      else if (r < 70) cyc(1, 0, A_CTRL, '0, ir, "R6 rand ctrl");
      else if (r < 72) cyc(1, 1, A_CTRL, {$urandom} | 32'h1 & ((($urandom % 4) != 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE), ir, "R2");
      else if (r < 75) cyc(1, 1, A_LO + 12'($urandom % 2), $urandom, ir, "R10");
      else             cyc(0, 0, '0, '0, ir, "R4 hold");
    end
    // reset mid-run
    rst_ni = 1'b0;
    model_clear();
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_(A_CTRL, "R1 ctrl after reset"); rd_(A_LO, "R1 count");
    if (seed == 0) $display("seed 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule